// File: doc/BRIEF.md
# Indirect Instruction and Data Memory Window

This block lets a host load and read back the instruction and data memories of a small embedded controller through a narrow register window, one 32-bit word per access. The window contains several independent access ports. Each port has a control register for instruction memory and one for data memory. Each port also has a data register for each memory and a tag register for instruction memory. The host writes the control register with a starting byte offset and an access mode. It then streams words through the data register. The port's word address can step forward on its own after each write, after each read, or both, and each of those two choices is made separately.

Instruction memory is divided into blocks of 64 words, or 256 bytes. Every block holds a tag and a secure flag. Each instruction word that is written copies the port's pending tag and its secure mode bit into the entries of the block that receives the word. A host loader therefore writes a new tag just before the first word of each block. A block that carries the secure flag returns zeros to every read through the window.

Top module: `iwin_mem_window`

## Requirements
- R1: After reset, every port's word address and mode bits are zero. Every instruction block's tag is zero and its secure flag is clear. `reg_rdata` is zero in any cycle that issues no read.
- R2: The register map is byte-addressed, and only word-aligned offsets are decoded. For port p, instruction control is at 0x180+16p, instruction data at 0x184+16p and tag at 0x188+16p. Data-memory control is at 0x1C0+16p and data-memory data at 0x1C4+16p. In the control word, bits [AW+1:2] give the start word (bits 1:0 are ignored), bit 24 enables write-advance, bit 25 enables read-advance and bit 28 sets secure (instruction ports only; a data-memory port stores 0 for it). A control read returns the current byte address together with these mode bits, and all other bits are zero.
- R3: A data write stores the word at the port's current address. The address then advances by one word only if write-advance is set; otherwise it holds.
- R4: A data read returns the word at the port's current address in the same cycle. The address then advances by one word only if read-advance is set. A cycle that asserts both write and read performs only the write.
- R5: Address advance wraps modulo the size of the memory being addressed.
- R6: A tag-register write sets the port's pending tag. Each instruction data write copies that pending tag and the port's secure bit into the 64-word block that holds the target word. A tag read returns the stored tag of the block that holds the port's current address.
- R7: An instruction data read from a block whose secure flag is set returns zero. A later non-secure write into that block clears the flag.
- R8: Accesses to one port leave the address, mode and pending tag of every other port unchanged.
- R9: The following accesses are unmapped: misaligned offsets, ports at index NPORTS or above, instruction offset 0xC, and data-memory offsets 0x8 and 0xC. Unmapped reads return zero, and unmapped writes change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read |

## Verification
The bench builds the block with a 512-byte instruction memory, which gives two tag blocks, and a 64-byte data memory, with two ports. With these sizes, a full-memory wrap, a crossing from one tag block into the next and a secure block next to an open one can all be reached in a few hundred cycles. Two ports leave the port slots 2 and 3 free, so the bench can probe them as unmapped addresses next to live ones. A behavioural model compares the read data on every clock. The model holds per-port addresses, the memory contents and the per-block tag and secure state.

// File: rtl/iwin_pkg.sv
`timescale 1ns/1ps
package iwin_pkg;
  localparam int unsigned WINC_BIT  = 24;
  localparam int unsigned RINC_BIT  = 25;
  localparam int unsigned SEC_BIT   = 28;
  localparam int unsigned BLK_WORDS = 64;
  localparam logic [5:0]  IMEM_PAGE = 6'h06;  // 0x180 >> 6
  localparam logic [5:0]  DMEM_PAGE = 6'h07;  // 0x1C0 >> 6

  typedef enum logic [1:0] {
    RK_CTRL = 2'd0,
    RK_DATA = 2'd1,
    RK_TAG  = 2'd2,
    RK_RSVD = 2'd3
  } iwin_reg_e;

  typedef struct packed {
    logic sec;
    logic rinc;
    logic winc;
  } iwin_mode_t;
endpackage

// File: rtl/iwin_rst_sync.sv
`timescale 1ns/1ps
module iwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/iwin_addr_port.sv
`timescale 1ns/1ps
module iwin_addr_port
  import iwin_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic            data_we,
  input  logic            data_re,
  input  logic [AW-1:0]   start_word,
  input  iwin_mode_t      mode_in,
  output logic [AW-1:0]   addr_q,
  output iwin_mode_t      mode_q
);
  logic [AW-1:0] addr_d;
  iwin_mode_t    mode_d;
  logic          step;
  logic          en;

  always_comb begin
    step   = (data_we && mode_q.winc) || (data_re && mode_q.rinc);
    en     = ctrl_we || step;
    addr_d = addr_q;
    mode_d = mode_q;
    if (ctrl_we) begin
      addr_d = start_word;
      mode_d = mode_in;
    end else if (step) begin
      addr_d = addr_q + 1'b1;  // natural wrap at memory size
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/iwin_imem.sv
`timescale 1ns/1ps
module iwin_imem
  import iwin_pkg::*;
#(
  parameter int unsigned WORDS = 1024,
  parameter int unsigned TAGW  = 16,
  localparam int unsigned AW   = $clog2(WORDS),
  localparam int unsigned NBLK = WORDS / BLK_WORDS,
  localparam int unsigned OFFW = $clog2(BLK_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [31:0]      wdata,
  input  logic [TAGW-1:0]  wtag,
  input  logic             wsec,
  input  logic [AW-1:0]    raddr,
  output logic [31:0]      rdata,
  output logic [TAGW-1:0]  rtag
);
  logic [31:0]                mem [WORDS];
  logic [NBLK-1:0][TAGW-1:0]  tag_q, tag_d;
  logic [NBLK-1:0]            sec_q, sec_d;
  logic [AW-OFFW-1:0]         wblk, rblk;

  assign wblk = waddr[AW-1:OFFW];
  assign rblk = raddr[AW-1:OFFW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    tag_d = tag_q;
    sec_d = sec_q;
    if (we) begin
      tag_d[wblk] = wtag;
      sec_d[wblk] = wsec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      sec_q <= '0;
    end else if (we) begin
      tag_q <= tag_d;
      sec_q <= sec_d;
    end
  end

  assign rdata = sec_q[rblk] ? '0 : mem[raddr];
  assign rtag  = tag_q[rblk];
endmodule

// File: rtl/iwin_dmem.sv
`timescale 1ns/1ps
module iwin_dmem #(
  parameter int unsigned WORDS = 512,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/iwin_mem_window.sv
`timescale 1ns/1ps
module iwin_mem_window
  import iwin_pkg::*;
#(
  parameter int unsigned NPORTS     = 2,     // 1..4
  parameter int unsigned IMEM_BYTES = 4096,  // >= 512, power of two
  parameter int unsigned DMEM_BYTES = 2048,  // power of two
  parameter int unsigned TAGW       = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int unsigned IWORDS = IMEM_BYTES / 4;
  localparam int unsigned DWORDS = DMEM_BYTES / 4;
  localparam int unsigned IAW    = $clog2(IWORDS);
  localparam int unsigned DAW    = $clog2(DWORDS);
  localparam int unsigned NBLK   = IWORDS / BLK_WORDS;

  logic        rst_sync_n;
  logic        word_ok, port_ok, i_hit, d_hit, acc_wr, acc_rd;
  logic [1:0]  pfield;
  iwin_reg_e   rk;
  iwin_mode_t  i_mode_in, d_mode_in;

  logic [NPORTS-1:0]            i_ctrl_we, i_data_we, i_data_re, i_tag_we;
  logic [NPORTS-1:0]            d_ctrl_we, d_data_we, d_data_re;
  logic [NPORTS-1:0][IAW-1:0]   i_addr;
  logic [NPORTS-1:0][DAW-1:0]   d_addr;
  iwin_mode_t [NPORTS-1:0]      i_mode, d_mode;
  logic [NPORTS-1:0][TAGW-1:0]  i_tag_q;

  logic [IAW-1:0]  i_sel_addr;
  logic [DAW-1:0]  d_sel_addr;
  iwin_mode_t      i_sel_mode, d_sel_mode;
  logic [TAGW-1:0] i_sel_tag, i_rtag;
  logic [31:0]     i_rdata, d_rdata, i_ctrl_rd, d_ctrl_rd;

  iwin_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // Register decode
  always_comb begin
    pfield  = reg_addr[5:4];
    rk      = iwin_reg_e'(reg_addr[3:2]);
    word_ok = (reg_addr[1:0] == 2'b00);
    port_ok = ({30'd0, pfield} < 32'(NPORTS));
    i_hit   = word_ok && port_ok && (reg_addr[11:6] == IMEM_PAGE);
    d_hit   = word_ok && port_ok && (reg_addr[11:6] == DMEM_PAGE);
    acc_wr  = reg_wr_en;
    acc_rd  = reg_rd_en && !reg_wr_en;
  end

  assign i_mode_in = '{sec: reg_wdata[SEC_BIT], rinc: reg_wdata[RINC_BIT], winc: reg_wdata[WINC_BIT]};
  assign d_mode_in = '{sec: 1'b0,               rinc: reg_wdata[RINC_BIT], winc: reg_wdata[WINC_BIT]};

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic            psel;
    logic [TAGW-1:0] tag_q, tag_d;

    assign psel         = (pfield == 2'(p));
    assign i_ctrl_we[p] = acc_wr && i_hit && psel && (rk == RK_CTRL);
    assign i_data_we[p] = acc_wr && i_hit && psel && (rk == RK_DATA);
    assign i_data_re[p] = acc_rd && i_hit && psel && (rk == RK_DATA);
    assign i_tag_we[p]  = acc_wr && i_hit && psel && (rk == RK_TAG);
    assign d_ctrl_we[p] = acc_wr && d_hit && psel && (rk == RK_CTRL);
    assign d_data_we[p] = acc_wr && d_hit && psel && (rk == RK_DATA);
    assign d_data_re[p] = acc_rd && d_hit && psel && (rk == RK_DATA);

    iwin_addr_port #(.AW(IAW)) u_iport (
      .clk(clk), .rst_n(rst_sync_n),
      .ctrl_we(i_ctrl_we[p]), .data_we(i_data_we[p]), .data_re(i_data_re[p]),
      .start_word(reg_wdata[IAW+1:2]), .mode_in(i_mode_in),
      .addr_q(i_addr[p]), .mode_q(i_mode[p])
    );

    iwin_addr_port #(.AW(DAW)) u_dport (
      .clk(clk), .rst_n(rst_sync_n),
      .ctrl_we(d_ctrl_we[p]), .data_we(d_data_we[p]), .data_re(d_data_re[p]),
      .start_word(reg_wdata[DAW+1:2]), .mode_in(d_mode_in),
      .addr_q(d_addr[p]), .mode_q(d_mode[p])
    );

    assign tag_d = i_tag_we[p] ? reg_wdata[TAGW-1:0] : tag_q;

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)      tag_q <= '0;
      else if (i_tag_we[p]) tag_q <= tag_d;
    end

    assign i_tag_q[p] = tag_q;
  end

  // Selected-port mux: one register access per cycle, so one port at a time
  always_comb begin
    i_sel_addr = '0;
    d_sel_addr = '0;
    i_sel_mode = '0;
    d_sel_mode = '0;
    i_sel_tag  = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (pfield == 2'(p)) begin
        i_sel_addr = i_addr[p];
        d_sel_addr = d_addr[p];
        i_sel_mode = i_mode[p];
        d_sel_mode = d_mode[p];
        i_sel_tag  = i_tag_q[p];
      end
    end
  end

  iwin_imem #(.WORDS(IWORDS), .TAGW(TAGW)) u_imem (
    .clk(clk), .rst_n(rst_sync_n),
    .we(|i_data_we), .waddr(i_sel_addr), .wdata(reg_wdata),
    .wtag(i_sel_tag), .wsec(i_sel_mode.sec),
    .raddr(i_sel_addr), .rdata(i_rdata), .rtag(i_rtag)
  );

  iwin_dmem #(.WORDS(DWORDS)) u_dmem (
    .clk(clk),
    .we(|d_data_we), .waddr(d_sel_addr), .wdata(reg_wdata),
    .raddr(d_sel_addr), .rdata(d_rdata)
  );

  // Control readback words
  always_comb begin
    i_ctrl_rd           = '0;
    i_ctrl_rd[IAW+1:2]  = i_sel_addr;
    i_ctrl_rd[WINC_BIT] = i_sel_mode.winc;
    i_ctrl_rd[RINC_BIT] = i_sel_mode.rinc;
    i_ctrl_rd[SEC_BIT]  = i_sel_mode.sec;
    d_ctrl_rd           = '0;
    d_ctrl_rd[DAW+1:2]  = d_sel_addr;
    d_ctrl_rd[WINC_BIT] = d_sel_mode.winc;
    d_ctrl_rd[RINC_BIT] = d_sel_mode.rinc;
    d_ctrl_rd[SEC_BIT]  = d_sel_mode.sec;
  end

  always_comb begin
    reg_rdata = '0;
    if (acc_rd && i_hit) begin
      case (rk)
        RK_CTRL: reg_rdata = i_ctrl_rd;
        RK_DATA: reg_rdata = i_rdata;
        RK_TAG:  reg_rdata = 32'(i_rtag);
        default: reg_rdata = '0;
      endcase
    end else if (acc_rd && d_hit) begin
      case (rk)
        RK_CTRL: reg_rdata = d_ctrl_rd;
        RK_DATA: reg_rdata = d_rdata;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/iwin_mem_window_chk.sv
`timescale 1ns/1ps
module iwin_mem_window_chk #(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned IAW    = 10,
  parameter int unsigned NBLK   = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NPORTS-1:0]          i_ctrl_we,
  input logic [NPORTS-1:0]          i_data_we,
  input logic [NPORTS-1:0]          i_data_re,
  input logic [NPORTS-1:0][IAW-1:0] i_addr,
  input logic [NPORTS-1:0][2:0]     i_mode,    // {sec, rinc, winc}
  input logic [IAW-1:0]             wr_word,
  input logic [31:0]                reg_rdata,
  input logic [NBLK-1:0]            sec_flags
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      i_ctrl_we[p] |=> (i_addr[p] == $past(wr_word)));

    assert_wr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (i_data_we[p] && i_mode[p][0]) |=> (i_addr[p] == $past(i_addr[p]) + 1'b1));

    assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (i_data_we[p] && !i_mode[p][0]) |=> $stable(i_addr[p]));

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (i_data_re[p] && !i_mode[p][1]) |=> $stable(i_addr[p]));

    assert_secure_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (i_data_re[p] && sec_flags[i_addr[p][IAW-1:6]]) |-> (reg_rdata == 32'd0));
  end
endmodule

bind iwin_mem_window iwin_mem_window_chk #(
  .NPORTS(NPORTS), .IAW(IAW), .NBLK(NBLK)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .i_ctrl_we(i_ctrl_we), .i_data_we(i_data_we), .i_data_re(i_data_re),
  .i_addr(i_addr), .i_mode(i_mode),
  .wr_word(reg_wdata[IAW+1:2]), .reg_rdata(reg_rdata),
  .sec_flags(u_imem.sec_q)
);

// File: tb/iwin_mem_window_tb.sv
`timescale 1ns/1ps
module iwin_mem_window_tb;
  localparam int NP = 2;
  localparam int IW = 128;  // 512 bytes
  localparam int DW = 16;   // 64 bytes

  localparam logic [11:0] I0C = 12'h180, I0D = 12'h184, I0T = 12'h188;
  localparam logic [11:0] I1C = 12'h190, I1D = 12'h194, I1T = 12'h198;
  localparam logic [11:0] D0C = 12'h1C0, D0D = 12'h1C4, D1C = 12'h1D0, D1D = 12'h1D4;
  localparam logic [31:0] WI = 32'h0100_0000, RI = 32'h0200_0000, SE = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en, reg_rd_en;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int          m_ia[NP], m_da[NP], m_tag[NP];
  bit          m_iw[NP], m_ir[NP], m_is[NP], m_dw[NP], m_dr[NP];
  logic [31:0] m_imem[IW];
  logic [31:0] m_dmem[DW];
  int          m_btag[IW/64];
  bit          m_bsec[IW/64];

  always #2 clk = ~clk;

  iwin_mem_window #(.NPORTS(NP), .IMEM_BYTES(IW*4), .DMEM_BYTES(DW*4), .TAGW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // 0 = unmapped, 1 = instruction window, 2 = data window
  function automatic int region(input logic [11:0] a);
    int ai = int'(a);
    if (ai % 4 != 0) return 0;
    if (ai >= 'h180 && ai < 'h180 + 16*NP && ((ai >> 2) & 3) != 3) return 1;
    if (ai >= 'h1C0 && ai < 'h1C0 + 16*NP && ((ai >> 2) & 3) < 2) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int p = (int'(a) >> 4) & 3;
    int r = (int'(a) >> 2) & 3;
    case (region(a))
      1: begin
        if (r == 0) return 32'(m_ia[p] * 4) | (m_iw[p] ? WI : 0) | (m_ir[p] ? RI : 0) | (m_is[p] ? SE : 0);
        if (r == 1) return m_bsec[m_ia[p] / 64] ? 32'd0 : m_imem[m_ia[p]];
        return 32'(m_btag[m_ia[p] / 64]);
      end
      2: begin
        if (r == 0) return 32'(m_da[p] * 4) | (m_dw[p] ? WI : 0) | (m_dr[p] ? RI : 0);
        return m_dmem[m_da[p]];
      end
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_update(input bit wr, input bit rd, input logic [11:0] a, input logic [31:0] d);
    int p = (int'(a) >> 4) & 3;
    int r = (int'(a) >> 2) & 3;
    int reg_n = region(a);
    if (wr) begin
      if (reg_n == 1) begin
        if (r == 0) begin
          m_ia[p] = int'(d >> 2) % IW; m_iw[p] = d[24]; m_ir[p] = d[25]; m_is[p] = d[28];
        end else if (r == 1) begin
          m_imem[m_ia[p]] = d;
          m_btag[m_ia[p] / 64] = m_tag[p];
          m_bsec[m_ia[p] / 64] = m_is[p];
          if (m_iw[p]) m_ia[p] = (m_ia[p] + 1) % IW;
        end else begin
          m_tag[p] = int'(d[15:0]);
        end
      end else if (reg_n == 2) begin
        if (r == 0) begin
          m_da[p] = int'(d >> 2) % DW; m_dw[p] = d[24]; m_dr[p] = d[25];
        end else begin
          m_dmem[m_da[p]] = d;
          if (m_dw[p]) m_da[p] = (m_da[p] + 1) % DW;
        end
      end
    end else if (rd) begin
      if (reg_n == 1 && r == 1 && m_ir[p]) m_ia[p] = (m_ia[p] + 1) % IW;
      if (reg_n == 2 && r == 1 && m_dr[p]) m_da[p] = (m_da[p] + 1) % DW;
    end
  endtask

  // One bus cycle: drive at negedge, compare before posedge, update model after it
  task automatic cyc(input bit wr, input bit rd, input logic [11:0] a, input logic [31:0] d, input string req);
    logic [31:0] exp;
    @(negedge clk);
    reg_wr_en = wr; reg_rd_en = rd; reg_addr = a; reg_wdata = d;
    #1;
    exp = (rd && !wr) ? m_read(a) : 32'd0;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, reg_rdata, exp);
    end
    @(posedge clk);
    m_update(wr, rd, a, d);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    cyc(1'b1, 1'b0, a, d, req);
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    cyc(1'b0, 1'b1, a, 32'd0, req);
  endtask

  task automatic idle(input string req);
    cyc(1'b0, 1'b0, 12'h000, 32'd0, req);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog all: actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      m_ia[i] = 0; m_da[i] = 0; m_tag[i] = 0;
      m_iw[i] = 0; m_ir[i] = 0; m_is[i] = 0; m_dw[i] = 0; m_dr[i] = 0;
    end
    for (int b = 0; b < IW/64; b++) begin m_btag[b] = 0; m_bsec[b] = 0; end
    rst_n = 1'b0; reg_wr_en = 0; reg_rd_en = 0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) idle("R1 idle");

    // R1: reset state visible through the window
    rd(I0C, "R1 ictrl p0"); rd(I1C, "R1 ictrl p1");
    rd(D0C, "R1 dctrl p0"); rd(D1C, "R1 dctrl p1");
    rd(I0T, "R1 tag p0");

    // R6, R3, R5: fill both blocks with a tag per block, wrap to zero
    wr(I0C, WI | RI, "R2 ictrl");
    wr(I0T, 32'h0000_00A5, "R6 tag a");
    for (int i = 0; i < IW; i++) begin
      if (i == 64) wr(I0T, 32'h0000_00B6, "R6 tag b");
      wr(I0D, (32'(i) * 32'h0101_0101) ^ 32'h5A00_0000, "R3 stream");
    end
    rd(I0C, "R5 wrap ictrl");
    // R4: read back all with read-advance
    for (int i = 0; i < IW; i++) rd(I0D, "R4 stream read");
    rd(I0T, "R6 tag block0");
    wr(I0C, 32'h0000_0100, "R2 ictrl blk1");
    rd(I0T, "R6 tag block1");
    rd(I0C, "R2 ictrl readback");

    // R2, R4, R3, R8: no advance, low bits ignored
    wr(I1C, 32'h0000_0013, "R2 ictrl p1");
    rd(I1C, "R2 ictrl p1 readback");
    rd(I1D, "R4 hold read a"); rd(I1D, "R4 hold read b");
    wr(I1D, 32'hDEAD_BEEF, "R3 hold write");
    rd(I1D, "R3 hold readback");
    rd(I1C, "R3 addr held");
    rd(I0C, "R8 p0 untouched");
    cyc(1'b1, 1'b1, I1D, 32'h1234_5678, "R4 wr and rd");
    rd(I1D, "R4 write won");

    // R7: secure block 1 via port 1
    wr(I1C, 32'h0000_0110 | WI | SE, "R2 secure ctrl");
    rd(I1C, "R2 secure readback");
    wr(I1T, 32'h0000_0077, "R6 tag secure");
    for (int i = 0; i < 4; i++) wr(I1D, 32'hC0DE_0000 + 32'(i), "R7 secure load");
    wr(I0C, 32'h0000_0110 | RI, "R2 p0 to blk1");
    for (int i = 0; i < 3; i++) rd(I0D, "R7 secure read");
    rd(I0T, "R6 tag after secure");
    wr(I0C, 32'h0000_0008 | RI, "R2 p0 to blk0");
    rd(I0D, "R7 open block read");
    rd(I1T, "R8 p1 tag kept");
    wr(I1C, 32'h0000_0120, "R2 p1 nonsecure");
    wr(I1D, 32'h0BAD_F00D, "R7 clear secure");
    wr(I0C, 32'h0000_0110 | RI, "R2 p0 to blk1 again");
    for (int i = 0; i < 5; i++) rd(I0D, "R7 cleared read");

    // Data memory: wrap, independent ports, secure bit ignored
    wr(D0C, WI | SE, "R2 dctrl p0");
    rd(D0C, "R2 dctrl no secure");
    for (int i = 0; i < DW; i++) wr(D0D, 32'hD000_0000 + 32'(i * 3), "R3 dmem stream");
    rd(D0C, "R5 dmem wrap");
    wr(D0D, 32'hFFFF_0001, "R5 dmem wrapped write");
    wr(D1C, 32'h0000_0020 | RI, "R2 dctrl p1");
    for (int i = 0; i < DW + 2; i++) rd(D1D, "R5 dmem read wrap");
    rd(D0C, "R8 dmem p0 kept");

    // R9: unmapped offsets
    wr(12'h1A0, 32'h0000_0040 | WI, "R9 port2 ctrl");
    wr(12'h1A4, 32'h1111_1111, "R9 port2 data");
    wr(12'h181, 32'h0000_0044, "R9 misaligned");
    wr(12'h18C, 32'h0000_0044, "R9 imem rsvd");
    wr(12'h1C8, 32'h0000_0044, "R9 dmem tag slot");
    wr(12'h1CC, 32'h0000_0044, "R9 dmem rsvd");
    wr(12'h000, 32'hFFFF_FFFF, "R9 low page");
    rd(12'h1A0, "R9 port2 read"); rd(12'h18C, "R9 rsvd read");
    rd(12'h1C8, "R9 dmem slot read"); rd(12'h181, "R9 misaligned read");
    rd(I0C, "R9 p0 ictrl kept"); rd(I1C, "R9 p1 ictrl kept");
    rd(D0C, "R9 p0 dctrl kept"); rd(D1C, "R9 p1 dctrl kept");
    rd(I0T, "R9 tag kept"); rd(I0D, "R9 data kept");
    repeat (2) idle("R1 idle zero");

    report();
    $finish;
  end
endmodule